// File: doc/BRIEF.md
# Ordered-Dither Pixel Packer

This block turns one blended colour result, held at 8 bits per component, into a packed 16-bit destination pixel. A format select chooses between a red-green-blue 5-6-5 layout and an alpha-red-green-blue 4-4-4-4 layout. Each component is cut down to its field width. Before the cut, an optional ordered dither may add a fraction of one output LSB, chosen by the destination pixel's position within a 4x4 tile. The dither is only allowed when the destination depth is 16 bits and the dither enable is set. When a component would pass the top code of its field, it saturates at all ones.

The block also holds the widening step that brings narrow source components up to 8 bits by repeating their high bits in the low positions. When `srcNarrow` is set, each input component is taken as a field-width value, right-aligned in its 8-bit port. It is widened first and then packed. Pixels move through a two-stage valid/ready pipeline, and a caller tag travels with each pixel.

Top module: `dither_packer`

## Requirements
- R1: While reset is held and just after it is released, `outValid` is 0 and `inReady` is 1.
- R2: With `fmtSel`=0 (5-6-5) and no dither, `outPixel` = {R[7:3], G[7:2], B[7:3]}, with red in bits 15:11, green in bits 10:5 and blue in bits 4:0. `inA` has no effect.
- R3: With `fmtSel`=1 (4-4-4-4) and no dither, `outPixel` = {A[7:4], R[7:4], G[7:4], B[7:4]}, with alpha in bits 15:12, red in 11:8, green in 7:4 and blue in 3:0.
- R4: The dither is applied only when `ditherEn`=1 and `depth16`=1. With any other combination, the components are truncated with nothing added.
- R5: When dithering, a component c with field width w becomes floor((8c + d*2^(8-w)) / 2^(11-w)), where d is the tile value in eighths. A result above 2^w-1 saturates to 2^w-1.
- R6: The tile value d, listed for x = `xPhase` 0..3, is 7,3,1,5 when `yPhase`=0; 1,5,7,3 when `yPhase`=1; 5,7,3,1 when `yPhase`=2; and 3,1,5,7 when `yPhase`=3.
- R7: In the 4-4-4-4 format, the alpha field receives the same dither offset as the colour fields.
- R8: With `srcNarrow`=1, the w low bits v of each input component are widened to 8 bits as (v << (8-w)) | (v >> (2w-8)) before packing, where w is the field width that component has in the selected format.
- R9: A pixel accepted at one rising edge appears on `outValid`/`outPixel`/`outTag` after the next rising edge, when `outReady` stays high. Pixels leave in order, each with its own tag.
- R10: While `outValid`=1 and `outReady`=0, the output pixel and tag hold steady and `inReady` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input pixel present |
| inReady | output | 1 | Block accepts a pixel this cycle |
| inA | input | 8 | Alpha component |
| inR | input | 8 | Red component |
| inG | input | 8 | Green component |
| inB | input | 8 | Blue component |
| xPhase | input | 2 | Destination X mod 4 |
| yPhase | input | 2 | Destination Y mod 4 |
| fmtSel | input | 1 | 0: 5-6-5, 1: 4-4-4-4 |
| ditherEn | input | 1 | Dither enable format bit |
| depth16 | input | 1 | Destination depth is 16 bits |
| srcNarrow | input | 1 | Components are field-width values to be widened |
| inTag | input | TagW | Caller tag |
| outValid | output | 1 | Output pixel present |
| outReady | input | 1 | Consumer takes the pixel |
| outPixel | output | 16 | Packed pixel |
| outTag | output | TagW | Tag of the output pixel |

## Verification
The assertions assume that `outReady` is driven on every cycle. They also assume that the producer keeps `inValid` and the pixel fields stable for one whole cycle, which the bench ensures by changing inputs only on the falling edge. The dither-step checks assume the component inputs are 8-bit results, so an added offset can raise the truncated code by at most one. The random stimulus sweeps all byte values, tile phases, formats and enable combinations. It draws `outReady` with gaps so that stalls occur often.

// File: rtl/dpk_pkg.sv
`timescale 1ns/1ps
package dpk_pkg;

  typedef enum logic {
    FMT_RGB565   = 1'b0,
    FMT_ARGB4444 = 1'b1
  } pixFmt_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic ld1;
    logic ld2;
  } pipeStb_t;

  // 4x4 ordered tile, values in eighths of an output LSB
  function automatic logic [2:0] ditherEighths(input logic [1:0] yPh, input logic [1:0] xPh);
    logic [2:0] d;
    case ({yPh, xPh})
      4'h0: d = 3'd7; 4'h1: d = 3'd3; 4'h2: d = 3'd1; 4'h3: d = 3'd5;
      4'h4: d = 3'd1; 4'h5: d = 3'd5; 4'h6: d = 3'd7; 4'h7: d = 3'd3;
      4'h8: d = 3'd5; 4'h9: d = 3'd7; 4'hA: d = 3'd3; 4'hB: d = 3'd1;
      default: begin
        case (xPh)
          2'd0: d = 3'd3; 2'd1: d = 3'd1; 2'd2: d = 3'd5; default: d = 3'd7;
        endcase
      end
    endcase
    return d;
  endfunction

  // replicate the w low bits of v into an 8-bit value, high bits first
  function automatic logic [7:0] widenComp(input logic [7:0] v, input int w);
    logic [7:0] res;
    for (int i = 0; i < 8; i++) begin
      res[7-i] = v[w - 1 - (i % w)];
    end
    return res;
  endfunction

  // field width of channel ch (0:A 1:R 2:G 3:B) in a format
  function automatic int chanWidth(input pixFmt_e fmt, input int ch);
    int w;
    if (fmt == FMT_ARGB4444) w = 4;
    else if (ch == 0)        w = 8;
    else if (ch == 2)        w = 6;
    else                     w = 5;
    return w;
  endfunction

endpackage

// File: rtl/dpk_quant.sv
`timescale 1ns/1ps
module dpk_quant #(
  parameter int CompW  = 8,
  parameter int FieldW = 5
) (
  input  logic [CompW-1:0]  comp,
  input  logic [2:0]        eighths,
  input  logic              addOn,
  output logic [FieldW-1:0] code
);
  localparam int FracW = CompW - FieldW;
  localparam int SumW  = CompW + 4;

  logic [SumW-1:0] sum;
  logic [SumW-1:0] offs;
  logic [FieldW:0] top;

  // value scaled by 8 so an eighth of an output LSB is an integer
  assign offs = addOn ? (SumW'(eighths) << FracW) : '0;
  assign sum  = {1'b0, comp, 3'b000} + offs;
  assign top  = sum[SumW-1 : FracW+3];
  assign code = top[FieldW] ? '1 : top[FieldW-1:0];

endmodule

// File: rtl/dpk_ctrl.sv
`timescale 1ns/1ps
module dpk_ctrl
  import dpk_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  output logic     inReady,
  output logic     outValid,
  input  logic     outReady,
  output pipeStb_t stb
);
  logic s1Valid;
  logic s2Valid;
  logic adv;

  assign adv      = outReady || !s2Valid;
  assign inReady  = adv;
  assign outValid = s2Valid;
  assign stb.ld1  = adv && inValid;
  assign stb.ld2  = adv && s1Valid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s2Valid <= 1'b0;
    end else if (adv) begin
      s1Valid <= inValid;
      s2Valid <= s1Valid;
    end
  end

  // R10: a stalled output stays presented
  a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);

  // R9: an accepted pixel occupies the first stage next cycle
  a_r9_accept_fill: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> s1Valid);

endmodule

// File: rtl/dpk_datapath.sv
`timescale 1ns/1ps
module dpk_datapath
  import dpk_pkg::*;
#(
  parameter int TagW = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pipeStb_t             stb,
  input  logic [3:0][7:0]      inComp,
  input  logic [1:0]           xPhase,
  input  logic [1:0]           yPhase,
  input  pixFmt_e              fmtSel,
  input  logic                 ditherEn,
  input  logic                 depth16,
  input  logic                 srcNarrow,
  input  logic [TagW-1:0]      inTag,
  output logic [15:0]          outPixel,
  output logic [TagW-1:0]      outTag
);
  localparam int NumCh = 4;

  logic [NumCh-1:0][7:0] wideComp;
  logic [NumCh-1:0][7:0] s1Comp;
  logic [2:0]            s1D;
  logic                  s1DOn;
  pixFmt_e               s1Fmt;
  logic [TagW-1:0]       s1Tag;

  // stage 1: optional widening of narrow source components
  for (genvar ch = 0; ch < NumCh; ch++) begin : g_widen
    always_comb begin
      if (srcNarrow) wideComp[ch] = widenComp(inComp[ch], chanWidth(fmtSel, ch));
      else           wideComp[ch] = inComp[ch];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Comp <= '0;
      s1D    <= '0;
      s1DOn  <= 1'b0;
      s1Fmt  <= FMT_RGB565;
      s1Tag  <= '0;
    end else if (stb.ld1) begin
      s1Comp <= wideComp;
      s1D    <= ditherEighths(yPhase, xPhase);
      s1DOn  <= ditherEn && depth16;
      s1Fmt  <= fmtSel;
      s1Tag  <= inTag;
    end
  end

  // stage 2: quantize every field of both layouts
  logic [4:0]            q565r;
  logic [5:0]            q565g;
  logic [4:0]            q565b;
  logic [NumCh-1:0][3:0] q4444;

  dpk_quant #(.CompW(8), .FieldW(5)) u_qR (
    .comp(s1Comp[1]), .eighths(s1D), .addOn(s1DOn), .code(q565r));
  dpk_quant #(.CompW(8), .FieldW(6)) u_qG (
    .comp(s1Comp[2]), .eighths(s1D), .addOn(s1DOn), .code(q565g));
  dpk_quant #(.CompW(8), .FieldW(5)) u_qB (
    .comp(s1Comp[3]), .eighths(s1D), .addOn(s1DOn), .code(q565b));

  for (genvar ch = 0; ch < NumCh; ch++) begin : g_q4
    dpk_quant #(.CompW(8), .FieldW(4)) u_q (
      .comp(s1Comp[ch]), .eighths(s1D), .addOn(s1DOn), .code(q4444[ch]));
  end

  logic [15:0] packed16;
  always_comb begin
    if (s1Fmt == FMT_ARGB4444) packed16 = {q4444[0], q4444[1], q4444[2], q4444[3]};
    else                       packed16 = {q565r, q565g, q565b};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outPixel <= '0;
      outTag   <= '0;
    end else if (stb.ld2) begin
      outPixel <= packed16;
      outTag   <= s1Tag;
    end
  end

  // R5: a dithered code never falls below the plain truncation
  a_r5_no_decrease: assert property (@(posedge clk) disable iff (!rstN)
    stb.ld2 |-> (q565g >= s1Comp[2][7:2]));

  // R5: the offset is under one LSB, so at most one step up
  a_r5_one_step: assert property (@(posedge clk) disable iff (!rstN)
    stb.ld2 |-> ({1'b0, q565g} <= ({1'b0, s1Comp[2][7:2]} + 7'd1)));

  // R4: with dithering off the alpha nibble equals the top input bits
  a_r4_plain_alpha: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ld2 && !s1DOn) |-> (q4444[0] == s1Comp[0][7:4]));

endmodule

// File: rtl/dither_packer.sv
`timescale 1ns/1ps
module dither_packer
  import dpk_pkg::*;
#(
  parameter int TagW = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  output logic            inReady,
  input  logic [7:0]      inA,
  input  logic [7:0]      inR,
  input  logic [7:0]      inG,
  input  logic [7:0]      inB,
  input  logic [1:0]      xPhase,
  input  logic [1:0]      yPhase,
  input  logic            fmtSel,
  input  logic            ditherEn,
  input  logic            depth16,
  input  logic            srcNarrow,
  input  logic [TagW-1:0] inTag,
  output logic            outValid,
  input  logic            outReady,
  output logic [15:0]     outPixel,
  output logic [TagW-1:0] outTag
);
  pipeStb_t        stb;
  logic [3:0][7:0] comps;
  pixFmt_e         fmt;

  assign comps[0] = inA;
  assign comps[1] = inR;
  assign comps[2] = inG;
  assign comps[3] = inB;
  assign fmt      = pixFmt_e'(fmtSel);

  dpk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .stb(stb));

  dpk_datapath #(.TagW(TagW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .inComp(comps),
    .xPhase(xPhase), .yPhase(yPhase), .fmtSel(fmt),
    .ditherEn(ditherEn), .depth16(depth16), .srcNarrow(srcNarrow),
    .inTag(inTag), .outPixel(outPixel), .outTag(outTag));

  // R10: output fields frozen during a stall
  a_r10_stall_stable: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> ($stable(outPixel) && $stable(outTag)));

endmodule

// File: tb/dither_packer_tb.sv
`timescale 1ns/1ps
module dither_packer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TagW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inReady, outValid, outReady = 1'b0;
  logic [7:0] inA = '0, inR = '0, inG = '0, inB = '0;
  logic [1:0] xPhase = '0, yPhase = '0;
  logic fmtSel = 1'b0, ditherEn = 1'b0, depth16 = 1'b0, srcNarrow = 1'b0;
  logic [TagW-1:0] inTag = '0, outTag;
  logic [15:0] outPixel;

  always #(CLK_PERIOD/2) clk = ~clk;

  dither_packer #(.TagW(TagW)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inA(inA), .inR(inR), .inG(inG), .inB(inB),
    .xPhase(xPhase), .yPhase(yPhase), .fmtSel(fmtSel),
    .ditherEn(ditherEn), .depth16(depth16), .srcNarrow(srcNarrow),
    .inTag(inTag), .outValid(outValid), .outReady(outReady),
    .outPixel(outPixel), .outTag(outTag));

  int checks = 0;
  int fails = 0;
  int iter = 0;
  bit finished = 1'b0;

  logic [15:0]     expQ[$];
  logic [TagW-1:0] tagQ[$];
  int              iterQ[$];
  string           reqQ[$];
  string           curReq = "R2";

  bit              prevStall = 1'b0;
  logic [15:0]     prevPix;
  logic [TagW-1:0] prevTag;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int tileD(input int y, input int x);
    int m[4][4] = '{'{7,3,1,5}, '{1,5,7,3}, '{5,7,3,1}, '{3,1,5,7}};
    return m[y][x];
  endfunction

  function automatic int widenE(input int c, input int w);
    int v;
    if (w == 8) return c;
    v = c & ((1 << w) - 1);
    return ((v << (8 - w)) | (v >> (2*w - 8))) & 255;
  endfunction

  function automatic int quantE(input int c, input int w, input int d, input bit en);
    int s, q;
    s = c * 8 + (en ? d * (1 << (8 - w)) : 0);
    q = s >> (11 - w);
    if (q > (1 << w) - 1) q = (1 << w) - 1;
    return q;
  endfunction

  function automatic logic [15:0] expPix();
    int d, a, r, g, b;
    bit en;
    en = ditherEn && depth16;
    d  = tileD(int'(yPhase), int'(xPhase));
    if (fmtSel) begin
      a = srcNarrow ? widenE(inA, 4) : int'(inA);
      r = srcNarrow ? widenE(inR, 4) : int'(inR);
      g = srcNarrow ? widenE(inG, 4) : int'(inG);
      b = srcNarrow ? widenE(inB, 4) : int'(inB);
      return 16'((quantE(a,4,d,en) << 12) | (quantE(r,4,d,en) << 8) |
                 (quantE(g,4,d,en) << 4)  |  quantE(b,4,d,en));
    end
    r = srcNarrow ? widenE(inR, 5) : int'(inR);
    g = srcNarrow ? widenE(inG, 6) : int'(inG);
    b = srcNarrow ? widenE(inB, 5) : int'(inB);
    return 16'((quantE(r,5,d,en) << 11) | (quantE(g,6,d,en) << 5) | quantE(b,5,d,en));
  endfunction

  // one cycle: inputs already set by caller; called right after a falling edge
  task automatic stepCycle(input bit v, input bit rdy, input bit exactLat);
    inValid  = v;
    outReady = rdy;
    #1;
    if (prevStall) begin
      check(outValid == 1'b1, "R10", int'(outValid), 1);
      check(outPixel == prevPix, "R10", int'(outPixel), int'(prevPix));
      check(outTag == prevTag, "R10", int'(outTag), int'(prevTag));
    end
    if (outValid && !outReady) check(inReady == 1'b0, "R10", int'(inReady), 0);
    if (outValid && outReady) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R9", int'(outPixel), -1);
      end else begin
        logic [15:0] e;
        logic [TagW-1:0] t;
        int it;
        string rq;
        e = expQ.pop_front(); t = tagQ.pop_front();
        it = iterQ.pop_front(); rq = reqQ.pop_front();
        check(outPixel == e, rq, int'(outPixel), int'(e));
        check(outTag == t, "R9", int'(outTag), int'(t));
        if (exactLat) check(iter == it + 2, "R9", iter - it, 2);
      end
    end
    prevStall = outValid && !outReady;
    prevPix   = outPixel;
    prevTag   = outTag;
    if (inValid && inReady) begin
      expQ.push_back(expPix());
      tagQ.push_back(inTag);
      iterQ.push_back(iter);
      reqQ.push_back(curReq);
    end
    iter++;
    @(negedge clk);
  endtask

  task automatic sendDirected(input string req, input bit fmt, input bit den, input bit d16,
                              input bit nar, input int x, input int y,
                              input int a, input int r, input int g, input int b);
    curReq = req;
    fmtSel = fmt; ditherEn = den; depth16 = d16; srcNarrow = nar;
    xPhase = 2'(x); yPhase = 2'(y);
    inA = 8'(a); inR = 8'(r); inG = 8'(g); inB = 8'(b);
    inTag = inTag + 1'b1;
    stepCycle(1'b1, 1'b1, 1'b1);
  endtask

  initial begin
    @(negedge clk);
    check(outValid == 1'b0, "R1", int'(outValid), 0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(outValid == 1'b0, "R1", int'(outValid), 0);
    check(inReady == 1'b1, "R1", int'(inReady), 1);
    @(negedge clk);

    // directed corners, output always ready
    sendDirected("R2", 0, 0, 0, 0, 0, 0, 8'h5A, 8'hFF, 8'h83, 8'h07);
    sendDirected("R2", 0, 0, 1, 0, 1, 2, 8'h00, 8'h12, 8'hFE, 8'hC9);
    sendDirected("R3", 1, 0, 1, 0, 2, 1, 8'hA7, 8'h3C, 8'h99, 8'h0F);
    sendDirected("R4", 0, 1, 0, 0, 0, 0, 8'h00, 8'hF8, 8'hFC, 8'h07);
    sendDirected("R4", 1, 0, 1, 0, 0, 0, 8'h1F, 8'h2F, 8'h3F, 8'h4F);
    sendDirected("R5", 0, 1, 1, 0, 0, 0, 8'h00, 8'hFF, 8'hFF, 8'hFF);
    sendDirected("R5", 0, 1, 1, 0, 2, 0, 8'h00, 8'h07, 8'h03, 8'h06);
    for (int y = 0; y < 4; y++) begin
      for (int x = 0; x < 4; x++) begin
        sendDirected("R6", 1, 1, 1, 0, x, y, 8'h08, 8'h18, 8'h0C, 8'h04);
      end
    end
    sendDirected("R7", 1, 1, 1, 0, 0, 0, 8'hF9, 8'h00, 8'h00, 8'h00);
    sendDirected("R7", 1, 1, 1, 0, 3, 3, 8'h38, 8'h00, 8'h00, 8'h00);
    sendDirected("R8", 0, 0, 0, 1, 0, 0, 8'h00, 8'h15, 8'h2A, 8'h1F);
    sendDirected("R8", 1, 0, 0, 1, 0, 0, 8'h09, 8'h0C, 8'h03, 8'h0F);
    sendDirected("R8", 0, 1, 1, 1, 0, 0, 8'h00, 8'h1E, 8'h3E, 8'h10);
    for (int k = 0; k < 4; k++) stepCycle(1'b0, 1'b1, 1'b1);

    // constrained random with stalls
    curReq = "R5";
    for (int n = 0; n < 4000; n++) begin
      bit v, rdy;
      v = ($urandom % 10) < 7;
      rdy = ($urandom % 4) != 0;
      fmtSel = 1'($urandom); ditherEn = 1'($urandom); depth16 = 1'($urandom);
      srcNarrow = (($urandom % 5) == 0);
      xPhase = 2'($urandom); yPhase = 2'($urandom);
      inA = 8'($urandom); inR = 8'($urandom); inG = 8'($urandom); inB = 8'($urandom);
      inTag = TagW'($urandom);
      stepCycle(v, rdy, 1'b0);
    end
    for (int k = 0; k < 8; k++) stepCycle(1'b0, 1'b1, 1'b0);
    check(expQ.size() == 0, "R9", expQ.size(), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule